// File: doc/BRIEF.md
# Line Frame Multiplexer and Demultiplexer

This block assembles the serial transmit line frame of a two-wire digital subscriber link from its channel inputs: two byte-wide bearer channels (B1 and B2), a signalling channel (D) of two bits per frame and a single housekeeping bit (HK). Beside the transmit side sits a matching demultiplexer that cuts a received serial frame back into the same channels. Both halves are paced by one bit strobe, `bitEn`, and share one frame position counter, so the receive side works on a frame alignment that is already known. No search for the frame alignment word is done here.

Two line rates are supported. At the low rate a framed frame is 10 bits long; at the high rate it is 20 bits. A framed frame opens with an alignment bit that alternates from frame to frame. One option sends idle ones in the D positions so that the host can carry signalling octets in the B1 slot instead. A transparent mode drops every overhead bit and carries only bearer data, 8 or 16 bits per frame.

The host presents the channel values and the mode selects before the strobe that starts a frame; they are taken in once, at that strobe. Each later strobe shifts out one more bit. On the receive side the channels carried by a frame appear on the outputs, with a one-cycle valid pulse, just after the strobe of its last bit.

Top module: `lineFrameMux`

## Requirements
- R1: While `rstN` is low and right after it, `txBit`, `rxValid`, `b1Out`, `b2Out`, `dOut` and `hkOut` are all 0.
- R2: Framed low rate (`rateHi`=0, `transparent`=0, `dInB1`=0): a frame is 10 bits sent as alignment bit, `dIn[1]`, then `b1In` MSB first.
- R3: Framed high rate (`rateHi`=1, `transparent`=0, `dInB1`=0): a frame is 20 bits sent as alignment bit, `hkIn`, `dIn[1]`, `dIn[0]`, `b1In` MSB first, `b2In` MSB first.
- R4: The alignment bit of the first framed frame after reset is 1 and it inverts on each following framed frame; transparent frames leave the sequence where it stood.
- R5: With `dInB1`=1 in framed mode every D position is sent as 1 whatever `dIn` holds, and the B1 slot still carries `b1In`.
- R6: With `transparent`=1 a frame holds only `b1In` MSB first (8 bits, `rateHi`=0) or `b1In` then `b2In`, both MSB first (16 bits, `rateHi`=1); no alignment, HK or D bit is sent.
- R7: Channel inputs and mode selects are taken only at the strobe that starts a frame; changing them during the rest of the frame does not alter the bits sent or the frame length.
- R8: `txBit` changes only in the cycle after a `bitEn` strobe and holds its value otherwise.
- R9: The bit on `rxBit` at each strobe is taken as the frame bit in the same position as the transmit bit of that strobe; one cycle after the last strobe of a frame, `rxValid` is high for exactly one cycle and `b1Out` (and `b2Out` when the frame carries B2) show the received bearer bytes.
- R10: `hkOut` takes the received HK bit only from framed high-rate frames and holds in every other mode.
- R11: On a framed low-rate frame `dOut` becomes {received D bit, 0}; on a framed high-rate frame it becomes the two received D bits in order; transparent frames leave `dOut` held, and low-rate frames leave `b2Out` held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit strobe: one line bit per high cycle |
| rateHi | input | 1 | 0 selects the 80 kbit/s format, 1 the 160 kbit/s format |
| transparent | input | 1 | 1 removes all overhead bits |
| dInB1 | input | 1 | 1 sends idle ones in the D positions |
| b1In | input | 8 | B1 byte for the next frame |
| b2In | input | 8 | B2 byte for the next frame |
| dIn | input | 2 | D bits for the next frame, bit 1 sent first |
| hkIn | input | 1 | Housekeeping bit for the next frame |
| txBit | output | 1 | Serial line bit |
| rxBit | input | 1 | Received serial line bit, aligned to the transmit frame |
| rxValid | output | 1 | One-cycle pulse when a received frame is complete |
| b1Out | output | 8 | Received B1 byte |
| b2Out | output | 8 | Received B2 byte |
| dOut | output | 2 | Received D bits |
| hkOut | output | 1 | Received housekeeping status bit |

## Verification
The hardest situations to reach are those where a field must hold while a frame of another format passes: HK kept across low-rate and transparent frames, D kept across transparent frames and B2 kept across low-rate frames. The vector table orders its frames so that each of these follows a frame that loaded a distinct value, and the receive line is driven with the expected transmit bits so that every loaded value is known. For the sampling rule, one directed frame inverts every channel input and every mode select right after the opening strobe, so a design that reads its inputs late sends a different frame length or different bits.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Frame format chosen at the start of each frame
  typedef struct packed {
    logic rateHi;
    logic transp;
    logic dInB1;
  } frameCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic bitStep;    // any bit strobe
    logic frameLoad;  // strobe that opens a frame
    logic frameLast;  // strobe of the last bit of a frame
  } ctlStrobe_t;

endpackage

// File: rtl/lfm_ctrl.sv
module lfm_ctrl
  import lfm_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  frameCfg_t  cfgIn,
  output frameCfg_t  cfgCur,
  output ctlStrobe_t strb,
  output logic       syncBit
);

  localparam int FRAME_MAX = 4 + 2 * CH_W;
  localparam int POS_W     = $clog2(FRAME_MAX);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] lastIdx;
  logic             atStart;

  assign atStart = (pos == '0);

  // Index of the final bit for the format in force
  always_comb begin
    unique case ({cfgCur.transp, cfgCur.rateHi})
      2'b00:   lastIdx = POS_W'(CH_W + 1);
      2'b01:   lastIdx = POS_W'(FRAME_MAX - 1);
      2'b10:   lastIdx = POS_W'(CH_W - 1);
      default: lastIdx = POS_W'(2 * CH_W - 1);
    endcase
  end

  assign strb.bitStep   = bitEn;
  assign strb.frameLoad = bitEn && atStart;
  assign strb.frameLast = bitEn && !atStart && (pos == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= '0;
      cfgCur  <= '0;
      syncBit <= 1'b1;
    end else if (bitEn) begin
      if (atStart) begin
        cfgCur <= cfgIn;
        pos    <= POS_W'(1);
        if (!cfgIn.transp) begin
          syncBit <= ~syncBit;
        end
      end else if (pos == lastIdx) begin
        pos <= '0;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/lfm_dpath.sv
module lfm_dpath
  import lfm_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strb,
  input  frameCfg_t       cfgIn,
  input  frameCfg_t       cfgCur,
  input  logic            syncBit,
  input  logic [CH_W-1:0] b1In,
  input  logic [CH_W-1:0] b2In,
  input  logic [1:0]      dIn,
  input  logic            hkIn,
  input  logic            rxBit,
  output logic            txBit,
  output logic            rxValid,
  output logic [CH_W-1:0] b1Out,
  output logic [CH_W-1:0] b2Out,
  output logic [1:0]      dOut,
  output logic            hkOut
);

  localparam int FRAME_MAX = 4 + 2 * CH_W;
  localparam int PAD_LO    = FRAME_MAX - CH_W - 2;
  localparam int PAD_T1    = FRAME_MAX - CH_W;
  localparam int PAD_T2    = FRAME_MAX - 2 * CH_W;

  logic [FRAME_MAX-1:0] newWord;
  logic [FRAME_MAX-1:0] txShift;
  logic [FRAME_MAX-1:0] rxShift;
  logic [FRAME_MAX-1:0] rxFull;
  logic [1:0]           dSlot;

  // ---------------- transmit: frame word, first bit at the MSB
  assign dSlot = cfgIn.dInB1 ? 2'b11 : dIn;

  always_comb begin
    unique case ({cfgIn.transp, cfgIn.rateHi})
      2'b00:   newWord = {syncBit, dSlot[1], b1In, {PAD_LO{1'b0}}};
      2'b01:   newWord = {syncBit, hkIn, dSlot, b1In, b2In};
      2'b10:   newWord = {b1In, {PAD_T1{1'b0}}};
      default: newWord = {b1In, b2In, {PAD_T2{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBit   <= 1'b0;
      txShift <= '0;
    end else if (strb.frameLoad) begin
      txBit   <= newWord[FRAME_MAX-1];
      txShift <= {newWord[FRAME_MAX-2:0], 1'b0};
    end else if (strb.bitStep) begin
      txBit   <= txShift[FRAME_MAX-1];
      txShift <= {txShift[FRAME_MAX-2:0], 1'b0};
    end
  end

  // ---------------- receive: shift in, cut fields on the last bit
  assign rxFull = {rxShift[FRAME_MAX-2:0], rxBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.bitStep) begin
      rxShift <= rxFull;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      b1Out   <= '0;
      b2Out   <= '0;
      dOut    <= '0;
      hkOut   <= 1'b0;
    end else begin
      rxValid <= strb.frameLast;
      if (strb.frameLast) begin
        unique case ({cfgCur.transp, cfgCur.rateHi})
          2'b00: begin
            b1Out <= rxFull[CH_W-1:0];
            dOut  <= {rxFull[CH_W], 1'b0};
          end
          2'b01: begin
            hkOut <= rxFull[FRAME_MAX-2];
            dOut  <= rxFull[2*CH_W+1 -: 2];
            b1Out <= rxFull[2*CH_W-1 -: CH_W];
            b2Out <= rxFull[CH_W-1:0];
          end
          2'b10: begin
            b1Out <= rxFull[CH_W-1:0];
          end
          default: begin
            b1Out <= rxFull[2*CH_W-1 -: CH_W];
            b2Out <= rxFull[CH_W-1:0];
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/lineFrameMux.sv
module lineFrameMux
  import lfm_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bitEn,
  input  logic            rateHi,
  input  logic            transparent,
  input  logic            dInB1,
  input  logic [CH_W-1:0] b1In,
  input  logic [CH_W-1:0] b2In,
  input  logic [1:0]      dIn,
  input  logic            hkIn,
  output logic            txBit,
  input  logic            rxBit,
  output logic            rxValid,
  output logic [CH_W-1:0] b1Out,
  output logic [CH_W-1:0] b2Out,
  output logic [1:0]      dOut,
  output logic            hkOut
);

  frameCfg_t  cfgIn;
  frameCfg_t  cfgCur;
  ctlStrobe_t strb;
  logic       syncBit;

  assign cfgIn = '{rateHi: rateHi, transp: transparent, dInB1: dInB1};

  lfm_ctrl #(.CH_W(CH_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .cfgIn   (cfgIn),
    .cfgCur  (cfgCur),
    .strb    (strb),
    .syncBit (syncBit)
  );

  lfm_dpath #(.CH_W(CH_W)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgIn   (cfgIn),
    .cfgCur  (cfgCur),
    .syncBit (syncBit),
    .b1In    (b1In),
    .b2In    (b2In),
    .dIn     (dIn),
    .hkIn    (hkIn),
    .rxBit   (rxBit),
    .txBit   (txBit),
    .rxValid (rxValid),
    .b1Out   (b1Out),
    .b2Out   (b2Out),
    .dOut    (dOut),
    .hkOut   (hkOut)
  );

endmodule

// File: rtl/lfm_check.sv
module lfm_check #(
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            bitEn,
  input logic            txBit,
  input logic            rxValid,
  input logic [CH_W-1:0] b1Out,
  input logic [CH_W-1:0] b2Out,
  input logic [1:0]      dOut,
  input logic            hkOut
);

  // R8: no strobe, no change on the line
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R9: the valid pulse lasts one cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R9: a completed frame always follows a strobe
  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(bitEn));

  // R10: the HK status moves only with a completed frame
  a_r10_hk_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hkOut) |-> rxValid);

  // R11: B2 and D move only with a completed frame
  a_r11_b2_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(b2Out) |-> rxValid);

  a_r11_d_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dOut) |-> rxValid);

  // R9: B1 moves only with a completed frame
  a_r9_b1_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(b1Out) |-> rxValid);

endmodule

bind lineFrameMux lfm_check #(.CH_W(CH_W)) i_lfm_check (
  .clk     (clk),
  .rstN    (rstN),
  .bitEn   (bitEn),
  .txBit   (txBit),
  .rxValid (rxValid),
  .b1Out   (b1Out),
  .b2Out   (b2Out),
  .dOut    (dOut),
  .hkOut   (hkOut)
);

// File: tb/test_lineFrameMux.sv
module test_lineFrameMux;

  localparam int CH_W = 8;
  localparam int NVEC = 8;

  // vector: [21] rateHi [20] transparent [19] dInB1 [18:11] b1 [10:3] b2 [2:1] d [0] hk
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 2'b10, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'h81, 8'h7E, 2'b01, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h0F, 8'hFF, 2'b01, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'hC3, 8'h5A, 2'b00, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'h96, 8'h11, 2'b11, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'hE7, 8'h18, 2'b10, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 2'b11, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 2'b00, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            bitEn = 1'b0;
  logic            rateHi = 1'b0;
  logic            transparent = 1'b0;
  logic            dInB1 = 1'b0;
  logic [CH_W-1:0] b1In = '0;
  logic [CH_W-1:0] b2In = '0;
  logic [1:0]      dIn = '0;
  logic            hkIn = 1'b0;
  logic            txBit;
  logic            rxBit = 1'b0;
  logic            rxValid;
  logic [CH_W-1:0] b1Out;
  logic [CH_W-1:0] b2Out;
  logic [1:0]      dOut;
  logic            hkOut;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  // bench model of expected receive state and alignment sequence
  logic            expSync;
  logic [CH_W-1:0] mB2;
  logic [1:0]      mD;
  logic            mHk;

  always #10 clk = ~clk;

  lineFrameMux #(.CH_W(CH_W)) i_lineFrameMux (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rateHi(rateHi),
    .transparent(transparent), .dInB1(dInB1), .b1In(b1In), .b2In(b2In),
    .dIn(dIn), .hkIn(hkIn), .txBit(txBit), .rxBit(rxBit), .rxValid(rxValid),
    .b1Out(b1Out), .b2Out(b2Out), .dOut(dOut), .hkOut(hkOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int frameLen(input logic r, input logic t);
    if (t) return r ? 16 : 8;
    return r ? 20 : 10;
  endfunction

  // expected line bits, first bit at bit 19
  function automatic logic [19:0] frameWord(input logic r, input logic t, input logic di,
      input logic [7:0] b1, input logic [7:0] b2, input logic [1:0] d,
      input logic hk, input logic s);
    logic [1:0] dd;
    dd = di ? 2'b11 : d;
    if (t) return r ? {b1, b2, 4'b0} : {b1, 12'b0};
    return r ? {s, hk, dd, b1, b2} : {s, dd[1], b1, 10'b0};
  endfunction

  task automatic runFrame(input logic r, input logic t, input logic di,
      input logic [7:0] b1, input logic [7:0] b2, input logic [1:0] d,
      input logic hk, input bit scramble);
    logic [19:0] w;
    logic [19:0] got;
    logic [1:0]  expD;
    int          len;
    bit          stableOk;
    bit          validOk;
    string       tag;
    rateHi = r; transparent = t; dInB1 = di;
    b1In = b1; b2In = b2; dIn = d; hkIn = hk;
    len = frameLen(r, t);
    w = frameWord(r, t, di, b1, b2, d, hk, expSync);
    got = '0;
    stableOk = 1'b1;
    validOk = 1'b1;
    for (int i = 0; i < len; i++) begin
      bitEn = 1'b1;
      rxBit = w[19-i];
      @(negedge clk);
      bitEn = 1'b0;
      got[19-i] = txBit;
      if (rxValid !== (i == len - 1)) validOk = 1'b0;
      if (scramble && i == 0) begin
        rateHi = ~r; transparent = ~t; dInB1 = ~di;
        b1In = ~b1; b2In = ~b2; dIn = ~d; hkIn = ~hk;
      end
      @(negedge clk);
      if (txBit !== got[19-i]) stableOk = 1'b0;
      if (rxValid !== 1'b0) validOk = 1'b0;
    end
    tag = scramble ? "R7" : (t ? "R6" : (di ? "R5" : (r ? "R3" : "R2")));
    check(got === w, tag, "line frame bits", 32'(got), 32'(w));
    if (!t) check(got[19] === expSync, "R4", "alignment bit", 32'(got[19]), 32'(expSync));
    check(stableOk, "R8", "line bit held between strobes", 32'(stableOk), 32'd1);
    check(validOk, "R9", "single valid pulse after last bit", 32'(validOk), 32'd1);
    check(b1Out === b1, "R9", "received B1", 32'(b1Out), 32'(b1));
    // update the receive model
    if (r) mB2 = b2;
    if (!t) begin
      expD = di ? 2'b11 : d;
      mD = r ? expD : {expD[1], 1'b0};
    end
    if (!t && r) mHk = hk;
    check(b2Out === mB2, r ? "R9" : "R11", "received or held B2", 32'(b2Out), 32'(mB2));
    check(dOut === mD, "R11", "received or held D", 32'(dOut), 32'(mD));
    check(hkOut === mHk, "R10", "received or held HK", 32'(hkOut), 32'(mHk));
    if (!t) expSync = ~expSync;
  endtask

  task automatic checkReset(input string when);
    check(txBit === 1'b0 && rxValid === 1'b0, "R1", {when, " line bit and valid"},
          {30'd0, txBit, rxValid}, 32'd0);
    check(b1Out === '0 && b2Out === '0 && dOut === '0 && hkOut === 1'b0, "R1",
          {when, " receive outputs"}, {13'd0, b1Out, b2Out, dOut, hkOut}, 32'd0);
  endtask

  initial begin
    expSync = 1'b1; mB2 = '0; mD = '0; mHk = 1'b0;
    repeat (3) @(negedge clk);
    checkReset("in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkReset("after reset");

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      runFrame(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18:11], VEC[v][10:3],
               VEC[v][2:1], VEC[v][0], 1'b0);
    end

    // R7: every input inverted right after the opening strobe
    runFrame(1'b1, 1'b0, 1'b0, 8'h3A, 8'hC5, 2'b10, 1'b0, 1'b1);
    runFrame(1'b0, 1'b1, 1'b0, 8'h5B, 8'h00, 2'b01, 1'b1, 1'b1);

    // R5: idle D positions at the high rate with D input all ones and zeros
    runFrame(1'b1, 1'b0, 1'b1, 8'h24, 8'h42, 2'b00, 1'b1, 1'b0);

    // R1 and R4: reset in mid-run restarts the alignment sequence
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkReset("mid-run reset");
    rstN = 1'b1;
    expSync = 1'b1; mB2 = '0; mD = '0; mHk = 1'b0;
    @(negedge clk);
    runFrame(1'b0, 1'b0, 1'b0, 8'h6D, 8'h00, 2'b11, 1'b0, 1'b0);
    runFrame(1'b1, 1'b0, 1'b0, 8'hB4, 8'h4B, 2'b10, 1'b1, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule